// File: doc/BRIEF.md
# DRAM Refresh Arbiter with Hidden and Forced Refresh

This block is the glue state machine between a processor bus and a two-mode DRAM controller-driver. In normal operation it keeps the controller in its automatic-access mode. A local read or write asks for a row strobe, and the controller does the rest. A bus cycle that does not address local memory also raises the row strobe request, so that the controller can slip a refresh into that cycle unseen.

A slow refresh clock marks the refresh windows. A window runs from one rising edge of the refresh clock to the next. If a window closes with no hidden refresh, a refresh becomes pending. An external refresh-request line sets the same pending flag. A pending refresh is served only from idle. The arbiter switches the controller to forced-refresh mode for a fixed number of processor cycles. It then holds that mode through a recovery delay before it returns to automatic access and clears the request. A local read that arrives during this time is stalled with WAIT. A local write gets no WAIT: its data-setup delay already holds it back, and its row strobe request simply starts after the refresh.

Top module: `dram_refresh_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, `mode_forced`, `row_req` and `wait_o` are all 0.
- R2: A local read (`rd_stb`=1, `cs_local`=1) that starts from idle in automatic mode raises `row_req` on the next clock edge. `row_req` stays high while the strobe is held and returns to 0 one edge after the strobe drops.
- R3: A local write (`wr_stb`=1, `rd_stb`=0, `cs_local`=1) that starts from idle raises `row_req` exactly WR_SETUP+1 clock edges after the strobe is first sampled, and not before.
- R4: A non-local bus cycle (`cs_local`=0 with either strobe high) in automatic mode raises `row_req` on the next edge and holds it for as long as the cycle lasts. This is the hidden refresh.
- R5: If a hidden refresh took place between two rising edges of `rfck`, the second edge raises no refresh, and `mode_forced` stays 0.
- R6: If a refresh-clock window closes with no hidden refresh, `mode_forced` goes to 1 and stays at 1 for exactly FORCE_CYC+REC_CYC consecutive cycles. `row_req` is 0 throughout.
- R7: A one-cycle pulse on `ext_refresh_req` starts the same forced refresh, with the same duration.
- R8: A local read that is pending while `mode_forced` is 1 drives `wait_o` to 1. `wait_o` stays 1 until the edge on which `mode_forced` falls. On the following edge the read's `row_req` rises. `wait_o` is never 1 while `mode_forced` is 0.
- R9: A local write during a forced refresh never causes `wait_o`. Its `row_req` rises WR_SETUP+1 edges after `mode_forced` falls.
- R10: A refresh request that arrives while an access holds `row_req` does not enter forced mode until the bus strobe has dropped. `mode_forced` never rises on the edge right after `row_req` was 1.
- R11: `row_req` and `mode_forced` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_local | input | 1 | 1 = the bus cycle addresses local DRAM |
| rd_stb | input | 1 | Processor read strobe, active high |
| wr_stb | input | 1 | Processor write strobe, active high |
| rfck | input | 1 | Refresh clock, asynchronous, synchronised inside |
| ext_refresh_req | input | 1 | Refresh request line, sets a pending refresh |
| mode_forced | output | 1 | Controller mode select: 0 = automatic access, 1 = forced refresh |
| row_req | output | 1 | Request to drive the row strobe active |
| wait_o | output | 1 | WAIT to the processor, active high |

## Verification
The bound checker covers the rules that must hold on every cycle. Row strobe and forced mode are mutually exclusive. WAIT appears only during forced mode and only for a local read sampled on the previous edge, never for a write. Forced mode never follows directly on a cycle with the row strobe active. Other behaviour spans many cycles and needs the directed scenarios: the exact read and write start latencies, the forced-mode duration, the suppression of a request by a hidden refresh, the deferral of a request behind an ongoing access, and the release of a stalled read or write after recovery.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ACCESS  = 3'd1,
    ST_HIDDEN  = 3'd2,
    ST_FORCED  = 3'd3,
    ST_RECOVER = 3'd4
  } arb_state_t;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/arb_edge_sync.sv
module arb_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/arb_refresh_window.sv
module arb_refresh_window (
  input  logic clk,
  input  logic rst,
  input  logic window_edge,
  input  logic hidden_evt,
  input  logic ext_req,
  input  logic clear,
  output logic pending
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q  <= 1'b1;
      pending <= 1'b0;
    end else begin
      if (window_edge) seen_q <= 1'b0;
      else if (hidden_evt) seen_q <= 1'b1;

      if (ext_req || (window_edge && !seen_q && !hidden_evt)) pending <= 1'b1;
      else if (clear) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_refresh_arbiter.sv
module dram_refresh_arbiter #(
  parameter int WR_SETUP  = 2,
  parameter int FORCE_CYC = 4,
  parameter int REC_CYC   = 3,
  parameter int SYNC_STG  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_local,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic rfck,
  input  logic ext_refresh_req,
  output logic mode_forced,
  output logic row_req,
  output logic wait_o
);
  import arb_pkg::*;

  localparam int CNT_MAX = max3(WR_SETUP, FORCE_CYC, REC_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  arb_state_t       state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             win_edge, pending, clr_pending, hidden_evt, bus_cyc;

  arb_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .async_in(rfck), .rise(win_edge)
  );

  arb_refresh_window u_window (
    .clk(clk), .rst(rst), .window_edge(win_edge), .hidden_evt(hidden_evt),
    .ext_req(ext_refresh_req), .clear(clr_pending), .pending(pending)
  );

  assign bus_cyc    = rd_stb | wr_stb;
  assign hidden_evt = (state == ST_IDLE) && (state_n == ST_HIDDEN);

  always_comb begin
    state_n     = state;
    cnt_n       = cnt;
    clr_pending = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (pending) begin
          state_n = ST_FORCED;
          cnt_n   = CNT_W'(FORCE_CYC - 1);
        end else if (bus_cyc && cs_local) begin
          state_n = ST_ACCESS;
          cnt_n   = rd_stb ? '0 : CNT_W'(WR_SETUP);
        end else if (bus_cyc) begin
          state_n = ST_HIDDEN;
        end
      end
      ST_ACCESS: begin
        if (!bus_cyc) begin
          state_n = ST_IDLE;
          cnt_n   = '0;
        end else if (cnt != '0) begin
          cnt_n = cnt - 1'b1;
        end
      end
      ST_HIDDEN: begin
        if (!bus_cyc) state_n = ST_IDLE;
      end
      ST_FORCED: begin
        if (cnt == '0) begin
          state_n = ST_RECOVER;
          cnt_n   = CNT_W'(REC_CYC - 1);
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      ST_RECOVER: begin
        if (cnt == '0) begin
          state_n     = ST_IDLE;
          clr_pending = 1'b1;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      mode_forced <= 1'b0;
      row_req     <= 1'b0;
      wait_o      <= 1'b0;
    end else begin
      state       <= state_n;
      cnt         <= cnt_n;
      mode_forced <= (state_n == ST_FORCED) || (state_n == ST_RECOVER);
      row_req     <= (state_n == ST_HIDDEN) || ((state_n == ST_ACCESS) && (cnt_n == '0));
      wait_o      <= rd_stb && cs_local &&
                     ((state_n == ST_FORCED) || (state_n == ST_RECOVER));
    end
  end
endmodule

// File: rtl/arb_checker.sv
module arb_checker (
  input logic clk,
  input logic rst,
  input logic cs_local,
  input logic rd_stb,
  input logic wr_stb,
  input logic mode_forced,
  input logic row_req,
  input logic wait_o
);
  assert_row_excludes_forced_R11: assert property (@(posedge clk) disable iff (rst)
    !(mode_forced && row_req));

  assert_wait_only_in_forced_R8: assert property (@(posedge clk) disable iff (rst)
    wait_o |-> mode_forced);

  assert_wait_needs_local_read_R8: assert property (@(posedge clk) disable iff (rst)
    wait_o |-> $past(rd_stb && cs_local));

  assert_no_wait_on_write_R9: assert property (@(posedge clk) disable iff (rst)
    $past(wr_stb && !rd_stb) |-> !wait_o);

  assert_no_refresh_over_access_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_forced) |-> !$past(row_req));
endmodule

bind dram_refresh_arbiter arb_checker u_arb_checker (
  .clk(clk), .rst(rst), .cs_local(cs_local), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .mode_forced(mode_forced), .row_req(row_req), .wait_o(wait_o)
);

// File: tb/test_dram_refresh_arbiter.sv
`timescale 1ns/1ps
module test_dram_refresh_arbiter;
  localparam int WR_SETUP  = 2;
  localparam int FORCE_CYC = 4;
  localparam int REC_CYC   = 3;

  logic clk = 1'b0;
  logic rst, cs_local, rd_stb, wr_stb, rfck, ext_refresh_req;
  logic mode_forced, row_req, wait_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dram_refresh_arbiter #(.WR_SETUP(WR_SETUP), .FORCE_CYC(FORCE_CYC), .REC_CYC(REC_CYC))
  i_dram_refresh_arbiter (
    .clk(clk), .rst(rst), .cs_local(cs_local), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .rfck(rfck), .ext_refresh_req(ext_refresh_req), .mode_forced(mode_forced),
    .row_req(row_req), .wait_o(wait_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic idle_bus();
    rd_stb = 1'b0; wr_stb = 1'b0; cs_local = 1'b0;
  endtask

  // waits until mode_forced rises, then returns its high duration and row_req activity
  task automatic measure_forced(input string req, output int dur, output int row_seen);
    int guard = 0;
    dur = 0; row_seen = 0;
    while (!mode_forced && guard < 30) begin step(1); guard++; end
    check(mode_forced == 1'b1, req, mode_forced, 1);
    while (mode_forced && dur < 50) begin
      if (row_req) row_seen++;
      dur++;
      step(1);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; idle_bus(); rfck = 1'b0; ext_refresh_req = 1'b0;
    step(3);
    check({mode_forced, row_req, wait_o} == 3'b000, "R1 in reset",
          {mode_forced, row_req, wait_o}, 0);
    rst = 1'b0;
    step(1);
    check({mode_forced, row_req, wait_o} == 3'b000, "R1 after reset",
          {mode_forced, row_req, wait_o}, 0);
  endtask

  task automatic t_local_read();
    cs_local = 1'b1; rd_stb = 1'b1;
    check(row_req == 1'b0, "R2 before edge", row_req, 0);
    step(1);
    check(row_req == 1'b1, "R2 one edge", row_req, 1);
    step(3);
    check(row_req == 1'b1, "R2 held", row_req, 1);
    idle_bus();
    step(1);
    check(row_req == 1'b0, "R2 released", row_req, 0);
    step(2);
  endtask

  task automatic t_local_write();
    cs_local = 1'b1; wr_stb = 1'b1;
    step(WR_SETUP);
    check(row_req == 1'b0, "R3 setup not elapsed", row_req, 0);
    step(1);
    check(row_req == 1'b1, "R3 after setup", row_req, 1);
    idle_bus();
    step(3);
  endtask

  task automatic t_hidden_suppresses();
    int seen = 0;
    rfck = 1'b1; step(6);
    cs_local = 1'b0; rd_stb = 1'b1;
    step(1);
    check(row_req == 1'b1, "R4 hidden row request", row_req, 1);
    step(2);
    check(row_req == 1'b1 && mode_forced == 1'b0, "R4 hidden held", row_req, 1);
    idle_bus();
    step(2);
    rfck = 1'b0; step(4);
    rfck = 1'b1;
    for (int i = 0; i < 12; i++) begin step(1); if (mode_forced) seen++; end
    check(seen == 0, "R5 no forced after hidden", seen, 0);
  endtask

  task automatic t_window_forced();
    int dur, rows;
    rfck = 1'b0; step(4);
    rfck = 1'b1;
    measure_forced("R6 forced entered", dur, rows);
    check(dur == FORCE_CYC + REC_CYC, "R6 forced duration", dur, FORCE_CYC + REC_CYC);
    check(rows == 0, "R6 row_req quiet", rows, 0);
    step(3);
  endtask

  task automatic t_ext_request();
    int dur, rows;
    ext_refresh_req = 1'b1; step(1); ext_refresh_req = 1'b0;
    measure_forced("R7 forced entered", dur, rows);
    check(dur == FORCE_CYC + REC_CYC, "R7 forced duration", dur, FORCE_CYC + REC_CYC);
    step(3);
  endtask

  task automatic t_read_stalled();
    int bad = 0;
    ext_refresh_req = 1'b1; step(1); ext_refresh_req = 1'b0;
    cs_local = 1'b1; rd_stb = 1'b1;
    step(1);
    check(mode_forced == 1'b1 && wait_o == 1'b1, "R8 wait raised",
          {mode_forced, wait_o}, 3);
    while (mode_forced) begin
      if (!wait_o || row_req) bad++;
      step(1);
    end
    check(bad == 0, "R8 wait held through refresh", bad, 0);
    check(wait_o == 1'b0 && row_req == 1'b0, "R8 wait drops with mode", wait_o, 0);
    step(1);
    check(row_req == 1'b1, "R8 read starts", row_req, 1);
    idle_bus();
    step(3);
  endtask

  task automatic t_write_no_wait();
    int w = 0;
    ext_refresh_req = 1'b1; step(1); ext_refresh_req = 1'b0;
    cs_local = 1'b1; wr_stb = 1'b1;
    step(1);
    check(mode_forced == 1'b1, "R9 forced entered", mode_forced, 1);
    while (mode_forced) begin
      if (wait_o || row_req) w++;
      step(1);
    end
    check(w == 0, "R9 no wait for write", w, 0);
    step(WR_SETUP);
    check(row_req == 1'b0, "R9 setup after refresh", row_req, 0);
    step(1);
    check(row_req == 1'b1, "R9 write starts", row_req, 1);
    idle_bus();
    step(3);
  endtask

  task automatic t_defer_behind_access();
    int m = 0;
    int dur, rows;
    cs_local = 1'b1; rd_stb = 1'b1;
    step(1);
    ext_refresh_req = 1'b1; step(1); ext_refresh_req = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (mode_forced || !row_req) m++;
      step(1);
    end
    check(m == 0, "R10 access not interrupted", m, 0);
    idle_bus();
    measure_forced("R10 deferred refresh runs", dur, rows);
    check(rows == 0, "R11 no row during forced", rows, 0);
    step(3);
  endtask

  initial begin
    t_reset();
    t_local_read();
    t_local_write();
    t_hidden_suppresses();
    t_window_forced();
    t_ext_request();
    t_read_stalled();
    t_write_no_wait();
    t_defer_behind_access();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule